// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block performs the state change a processor core makes when it takes an exception and when it returns from one. On entry it receives a cause code together with the address of the next instruction and the current machine state word. It writes a return address and a filtered copy of the state word into a save register pair, builds a fresh state word for the handler, and forms the handler address. That address is the cause's entry in a computed vector table ORed with a base prefix.

On a return command it reads the selected save pair and forces the restored address to word alignment. It then produces the restored state word through a mask chosen by the return kind. All results are registered and are held on `new_pc`/`new_msr` until the next entry or return. One-cycle pulses mark a taken exception, a completed return and an undefined vector. A sticky checkstop flag covers a machine check that arrives while machine checks are disabled.

A build-time option selects the classic or the embedded variant. The variant decides whether the saved state word is filtered and whether some causes also copy their saved values into an alternate pair.

Top module: `exc_seq`

## Requirements
- R1: After reset, `new_pc`, `new_msr` and every save pair read zero, and `taken`, `ret_done`, `vec_err` and `checkstop` are 0.
- R2: On entry, the classic variant saves the state word with the bits of mask 0x783F0000 cleared. The embedded variant saves the state word unchanged.
- R3: Causes marked as restarting (default causes 3, 4, 6, 7, 8) save `cur_pc - 4` as the return address. All other causes save `cur_pc`.
- R4: The handler state word is all zeros except for two bits. The machine-check-enable bit (bit 12) is copied from `cur_msr`. The little-endian bit (bit 0) is set when the interrupt-little-endian bit (bit 16) of `cur_msr` is set.
- R5: The machine-check cause (cause 2) clears bit 12 in the handler state word. If it arrives while `cur_msr` bit 12 is 0, the block sets `checkstop` and does not vector or write any save pair. While `checkstop` is set, later entries and returns have no effect until reset.
- R6: A taken entry raises `taken` for one cycle, one clock after the request. `new_pc` then equals cause × 0x100 ORed with `exc_prefix`.
- R7: A cause whose vector entry is all ones (default causes 24 to 31) raises `vec_err` for one cycle. It does not raise `taken` and writes no save pair.
- R8: Critical causes (default 1 and 12) save into pair 1 and all other causes save into pair 0. In the embedded variant, causes 2 and 11 also copy their saved values into pair 2.
- R9: The return kind `ret_kind` is encoded as follows. With 0, the block reads pair 0 and masks with ~0x783F0000. With 1, it reads pair 1 and masks with ~0xFFFF0000. With 2, it reads pair 0 with no mask. With 3, it reads pair 2 with no mask. The restored address has its two low bits cleared, and `ret_done` pulses one clock after the request.
- R10: For return kind 0 with `ret_keep_hi` set, bits 63:32 of the restored word are taken from `cur_msr`. Only bits 31:0 come from the masked saved word.
- R11: A return requested in the same cycle as an entry is held. It is carried out in the next cycle without an entry, after the entry has updated the save pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | Entry request |
| exc_cause | input | 5 | Cause code of the entry |
| cur_pc | input | 64 | Address of the next instruction |
| cur_msr | input | 64 | Current machine state word |
| exc_prefix | input | 64 | Base ORed into the handler address |
| ret_valid | input | 1 | Return request |
| ret_kind | input | 2 | Return kind (pair and mask, see R9) |
| ret_keep_hi | input | 1 | Keep the upper state half on kind 0 |
| new_pc | output | 64 | Handler or restored address |
| new_msr | output | 64 | Handler or restored state word |
| taken | output | 1 | Entry completed (one-cycle pulse) |
| ret_done | output | 1 | Return completed (one-cycle pulse) |
| vec_err | output | 1 | Undefined vector hit (one-cycle pulse) |
| checkstop | output | 1 | Sticky checkstop state |
| save_pc | output | 192 | Return addresses of pairs 2..0 |
| save_msr | output | 192 | Saved state words of pairs 2..0 |

## Verification
Every result of an entry or a plain return, including the save pairs, is registered once. It is due on the first clock edge after the edge that samples the request. A return held behind an entry is due one edge later. The bench drives each request 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge. For the held return it waits one more edge before reading `ret_done` and the restored values. A classic and an embedded instance share the stimulus, so the variant-dependent saved word and the alternate pair are compared side by side.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
   localparam int NPAIR    = 3;
   localparam int PAIR_PRI = 0;
   localparam int PAIR_CRT = 1;
   localparam int PAIR_ALT = 2;

   typedef enum logic [1:0] {
      RK_CLASSIC  = 2'd0,
      RK_LEG_CRIT = 2'd1,
      RK_EMB_PRI  = 2'd2,
      RK_EMB_ALT  = 2'd3
   } ret_kind_e;
endpackage

// File: rtl/exc_vector_table.sv
module exc_vector_table #(
   parameter int                     XLEN       = 64,
   parameter int                     CAUSE_W    = 5,
   parameter longint unsigned        VEC_BASE   = 0,
   parameter longint unsigned        VEC_STRIDE = 64'h100,
   parameter logic [(1<<CAUSE_W)-1:0] UNDEF_MASK = 32'hFF00_0000
) (
   input  logic [CAUSE_W-1:0] cause,
   output logic [XLEN-1:0]    vec,
   output logic               undef
);
   localparam int NCAUSE = 1 << CAUSE_W;

   logic [XLEN-1:0] tbl [NCAUSE];

   for (genvar c = 0; c < NCAUSE; c++) begin : g_ent
      if (UNDEF_MASK[c]) begin : g_none
         assign tbl[c] = '1;
      end else begin : g_def
         assign tbl[c] = XLEN'(VEC_BASE + longint'(c) * VEC_STRIDE);
      end
   end

   assign vec   = tbl[cause];
   assign undef = (vec == '1);
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc #(
   parameter int                      XLEN         = 64,
   parameter int                      CAUSE_W      = 5,
   parameter bit                      EMBEDDED     = 1'b0,
   parameter int                      ME_BIT       = 12,
   parameter int                      ILE_BIT      = 16,
   parameter int                      LE_BIT       = 0,
   parameter int                      MCHK_CAUSE   = 2,
   parameter logic [(1<<CAUSE_W)-1:0] RESTART_MASK = 32'h0000_01D8,
   parameter logic [(1<<CAUSE_W)-1:0] CRIT_MASK    = 32'h0000_1002,
   parameter logic [(1<<CAUSE_W)-1:0] ALT_MASK     = 32'h0000_0804
) (
   input  logic [CAUSE_W-1:0] cause,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [XLEN-1:0]    cur_msr,
   output logic [XLEN-1:0]    sv_pc,
   output logic [XLEN-1:0]    sv_msr,
   output logic [XLEN-1:0]    hnd_msr,
   output logic [1:0]         pri_pair,
   output logic               alt_copy,
   output logic               mchk_stop
);
   import exc_seq_pkg::*;

   localparam logic [XLEN-1:0] SAVE_KEEP = ~(XLEN'(32'h783F_0000));

   logic is_mchk;

   assign is_mchk   = (cause == CAUSE_W'(MCHK_CAUSE));
   assign mchk_stop = is_mchk && !cur_msr[ME_BIT];
   assign sv_pc     = RESTART_MASK[cause] ? cur_pc - XLEN'(4) : cur_pc;
   assign pri_pair  = CRIT_MASK[cause] ? 2'(PAIR_CRT) : 2'(PAIR_PRI);

   if (EMBEDDED) begin : g_emb
      assign sv_msr   = cur_msr;
      assign alt_copy = ALT_MASK[cause];
   end else begin : g_cls
      assign sv_msr   = cur_msr & SAVE_KEEP;
      assign alt_copy = 1'b0;
   end

   always_comb begin
      hnd_msr         = '0;
      hnd_msr[ME_BIT] = cur_msr[ME_BIT] && !is_mchk;
      hnd_msr[LE_BIT] = cur_msr[ILE_BIT];
   end
endmodule

// File: rtl/exc_return_calc.sv
module exc_return_calc #(
   parameter int XLEN = 64
) (
   input  logic [1:0]                              kind,
   input  logic                                    keep_hi,
   input  logic [XLEN-33:0]                        cur_hi,
   input  logic [exc_seq_pkg::NPAIR-1:0][XLEN-1:0] pair_pc,
   input  logic [exc_seq_pkg::NPAIR-1:0][XLEN-1:0] pair_msr,
   output logic [XLEN-1:0]                         rs_pc,
   output logic [XLEN-1:0]                         rs_msr
);
   import exc_seq_pkg::*;

   localparam logic [XLEN-1:0] CLS_MASK = ~(XLEN'(32'h783F_0000));
   localparam logic [XLEN-1:0] LEG_MASK = ~(XLEN'(32'hFFFF_0000));

   ret_kind_e       rk;
   logic [1:0]      sel;
   logic [XLEN-1:0] mask;
   logic [XLEN-1:0] raw;

   assign rk = ret_kind_e'(kind);

   always_comb begin
      unique case (rk)
         RK_CLASSIC:  begin sel = 2'(PAIR_PRI); mask = CLS_MASK; end
         RK_LEG_CRIT: begin sel = 2'(PAIR_CRT); mask = LEG_MASK; end
         RK_EMB_PRI:  begin sel = 2'(PAIR_PRI); mask = '1;       end
         default:     begin sel = 2'(PAIR_ALT); mask = '1;       end
      endcase
   end

   assign raw   = pair_msr[sel] & mask;
   assign rs_pc = {pair_pc[sel][XLEN-1:2], 2'b00};
   assign rs_msr = (rk == RK_CLASSIC && keep_hi) ? {cur_hi, raw[31:0]} : raw;
endmodule

// File: rtl/exc_seq.sv
module exc_seq #(
   parameter int                      XLEN         = 64,
   parameter int                      CAUSE_W      = 5,
   parameter bit                      EMBEDDED     = 1'b0,
   parameter int                      ME_BIT       = 12,
   parameter int                      ILE_BIT      = 16,
   parameter int                      LE_BIT       = 0,
   parameter int                      MCHK_CAUSE   = 2,
   parameter longint unsigned         VEC_BASE     = 0,
   parameter longint unsigned         VEC_STRIDE   = 64'h100,
   parameter logic [(1<<CAUSE_W)-1:0] UNDEF_MASK   = 32'hFF00_0000,
   parameter logic [(1<<CAUSE_W)-1:0] RESTART_MASK = 32'h0000_01D8,
   parameter logic [(1<<CAUSE_W)-1:0] CRIT_MASK    = 32'h0000_1002,
   parameter logic [(1<<CAUSE_W)-1:0] ALT_MASK     = 32'h0000_0804
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    exc_valid,
   input  logic [CAUSE_W-1:0]                      exc_cause,
   input  logic [XLEN-1:0]                         cur_pc,
   input  logic [XLEN-1:0]                         cur_msr,
   input  logic [XLEN-1:0]                         exc_prefix,
   input  logic                                    ret_valid,
   input  logic [1:0]                              ret_kind,
   input  logic                                    ret_keep_hi,
   output logic [XLEN-1:0]                         new_pc,
   output logic [XLEN-1:0]                         new_msr,
   output logic                                    taken,
   output logic                                    ret_done,
   output logic                                    vec_err,
   output logic                                    checkstop,
   output logic [exc_seq_pkg::NPAIR-1:0][XLEN-1:0] save_pc,
   output logic [exc_seq_pkg::NPAIR-1:0][XLEN-1:0] save_msr
);
   import exc_seq_pkg::*;

   if (XLEN < 64) begin : g_bad_xlen
      $error("exc_seq: XLEN must be at least 64");
   end
   if (ME_BIT >= XLEN || ILE_BIT >= XLEN || LE_BIT >= XLEN) begin : g_bad_bit
      $error("exc_seq: state bit position outside XLEN");
   end
   if (MCHK_CAUSE >= (1 << CAUSE_W)) begin : g_bad_mchk
      $error("exc_seq: machine-check cause out of range");
   end

   logic [XLEN-1:0] vec, sv_pc, sv_msr, hnd_msr, rs_pc, rs_msr;
   logic            undef, alt_copy, mchk_stop;
   logic [1:0]      pri_pair;

   logic            pend_q;
   logic [1:0]      pend_kind_q;
   logic            pend_keep_q;

   logic            fire, entry_ok, ret_req, do_ret;
   logic [1:0]      kind_sel;
   logic            keep_sel;

   exc_vector_table #(
      .XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_BASE(VEC_BASE),
      .VEC_STRIDE(VEC_STRIDE), .UNDEF_MASK(UNDEF_MASK)
   ) u_vec (
      .cause(exc_cause), .vec(vec), .undef(undef)
   );

   exc_entry_calc #(
      .XLEN(XLEN), .CAUSE_W(CAUSE_W), .EMBEDDED(EMBEDDED),
      .ME_BIT(ME_BIT), .ILE_BIT(ILE_BIT), .LE_BIT(LE_BIT),
      .MCHK_CAUSE(MCHK_CAUSE), .RESTART_MASK(RESTART_MASK),
      .CRIT_MASK(CRIT_MASK), .ALT_MASK(ALT_MASK)
   ) u_ent (
      .cause(exc_cause), .cur_pc(cur_pc), .cur_msr(cur_msr),
      .sv_pc(sv_pc), .sv_msr(sv_msr), .hnd_msr(hnd_msr),
      .pri_pair(pri_pair), .alt_copy(alt_copy), .mchk_stop(mchk_stop)
   );

   exc_return_calc #(.XLEN(XLEN)) u_ret (
      .kind(kind_sel), .keep_hi(keep_sel), .cur_hi(cur_msr[XLEN-1:32]),
      .pair_pc(save_pc), .pair_msr(save_msr),
      .rs_pc(rs_pc), .rs_msr(rs_msr)
   );

   // An entry wins the cycle; a return seen alongside it waits one slot.
   assign fire     = exc_valid && !checkstop;
   assign entry_ok = fire && !undef && !mchk_stop;
   assign ret_req  = pend_q || ret_valid;
   assign do_ret   = ret_req && !exc_valid && !checkstop;
   assign kind_sel = pend_q ? pend_kind_q : ret_kind;
   assign keep_sel = pend_q ? pend_keep_q : ret_keep_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_kind_q <= '0;
         pend_keep_q <= 1'b0;
      end else if (checkstop) begin
         pend_q      <= 1'b0;
      end else if (exc_valid) begin
         pend_q      <= ret_req;
         pend_kind_q <= kind_sel;
         pend_keep_q <= keep_sel;
      end else if (pend_q && ret_valid) begin
         pend_q      <= 1'b1;
         pend_kind_q <= ret_kind;
         pend_keep_q <= ret_keep_hi;
      end else begin
         pend_q      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         new_pc    <= '0;
         new_msr   <= '0;
         taken     <= 1'b0;
         ret_done  <= 1'b0;
         vec_err   <= 1'b0;
         checkstop <= 1'b0;
      end else begin
         taken    <= entry_ok;
         ret_done <= do_ret;
         vec_err  <= fire && undef;
         if (fire && !undef && mchk_stop) begin
            checkstop <= 1'b1;
         end
         if (entry_ok) begin
            new_pc  <= vec | exc_prefix;
            new_msr <= hnd_msr;
         end else if (do_ret) begin
            new_pc  <= rs_pc;
            new_msr <= rs_msr;
         end
      end
   end

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      logic wr;
      assign wr = entry_ok &&
                  ((pri_pair == 2'(p)) || (alt_copy && p == PAIR_ALT));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            save_pc[p]  <= '0;
            save_msr[p] <= '0;
         end else if (wr) begin
            save_pc[p]  <= sv_pc;
            save_msr[p] <= sv_msr;
         end
      end
   end
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk #(
   parameter int XLEN       = 64,
   parameter int CAUSE_W    = 5,
   parameter int ME_BIT     = 12,
   parameter int LE_BIT     = 0,
   parameter int MCHK_CAUSE = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               exc_valid,
   input logic [CAUSE_W-1:0] exc_cause,
   input logic               ret_valid,
   input logic [XLEN-1:0]    new_pc,
   input logic [XLEN-1:0]    new_msr,
   input logic               taken,
   input logic               ret_done,
   input logic               vec_err,
   input logic               checkstop
);
   localparam logic [XLEN-1:0] HND_BITS = (XLEN'(1) << ME_BIT) | (XLEN'(1) << LE_BIT);

   a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
      !(taken && ret_done));

   a_r5_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |=> checkstop);

   a_r5_stop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      checkstop |-> (!taken && !ret_done));

   a_r9_ret_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      ret_done |-> (new_pc[1:0] == 2'b00));

   a_r4_hnd_msr_clean: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> ((new_msr & ~HND_BITS) == '0));

   a_r5_mchk_no_me: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && $past(exc_valid && exc_cause == CAUSE_W'(MCHK_CAUSE)))
         |-> !new_msr[ME_BIT]);

   a_r7_err_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      vec_err |-> !taken);

   a_r11_held_ret: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && ret_valid && !checkstop && exc_cause != CAUSE_W'(MCHK_CAUSE))
         ##1 !exc_valid |=> ret_done);
endmodule

bind exc_seq exc_seq_chk #(
   .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ME_BIT(ME_BIT),
   .LE_BIT(LE_BIT), .MCHK_CAUSE(MCHK_CAUSE)
) i_chk (
   .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
   .ret_valid(ret_valid), .new_pc(new_pc), .new_msr(new_msr),
   .taken(taken), .ret_done(ret_done), .vec_err(vec_err),
   .checkstop(checkstop)
);

// File: tb/test_exc_seq.sv
module test_exc_seq;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic exc_valid = 1'b0;
   logic [4:0] exc_cause = '0;
   logic [63:0] cur_pc = '0, cur_msr = '0, exc_prefix = '0;
   logic ret_valid = 1'b0;
   logic [1:0] ret_kind = '0;
   logic ret_keep_hi = 1'b0;

   logic [63:0] c_pc, c_msr, e_pc, e_msr;
   logic c_tk, c_rd, c_ve, c_cs, e_tk, e_rd, e_ve, e_cs;
   logic [2:0][63:0] c_spc, c_smsr, e_spc, e_smsr;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_seq i_exc_seq (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
      .cur_pc(cur_pc), .cur_msr(cur_msr), .exc_prefix(exc_prefix),
      .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_keep_hi(ret_keep_hi),
      .new_pc(c_pc), .new_msr(c_msr), .taken(c_tk), .ret_done(c_rd),
      .vec_err(c_ve), .checkstop(c_cs), .save_pc(c_spc), .save_msr(c_smsr));

   exc_seq #(.EMBEDDED(1'b1)) i_exc_seq_emb (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
      .cur_pc(cur_pc), .cur_msr(cur_msr), .exc_prefix(exc_prefix),
      .ret_valid(ret_valid), .ret_kind(ret_kind), .ret_keep_hi(ret_keep_hi),
      .new_pc(e_pc), .new_msr(e_msr), .taken(e_tk), .ret_done(e_rd),
      .vec_err(e_ve), .checkstop(e_cs), .save_pc(e_spc), .save_msr(e_smsr));

   typedef struct packed {
      logic [4:0]  cause;
      logic [63:0] pc;
      logic [63:0] msr;
      logic [63:0] pfx;
      logic [63:0] x_npc;
      logic [63:0] x_nmsr;
      logic [1:0]  pair;
      logic [63:0] x_spc;
      logic [63:0] x_smsr;
   } vec_t;

   // R2 R3 R4 R5 R6 R8 on the classic instance
   localparam vec_t TBL [5] = '{
      '{5'd5,  64'h1000, 64'h8000_0000_783F_9032, 64'h0, 64'h500,
        64'h1001, 2'd0, 64'h1000, 64'h8000_0000_0000_9032},
      '{5'd3,  64'h2000, 64'h2, 64'hFFF0_0000, 64'hFFF0_0300,
        64'h0, 2'd0, 64'h1FFC, 64'h2},
      '{5'd12, 64'h3004, 64'h1000, 64'h0, 64'hC00,
        64'h1000, 2'd1, 64'h3004, 64'h1000},
      '{5'd2,  64'h4000, 64'h1_1000, 64'h0, 64'h200,
        64'h1, 2'd0, 64'h4000, 64'h1000},
      '{5'd9,  64'h5008, 64'h7FFF_FFFF, 64'h0, 64'h900,
        64'h1001, 2'd0, 64'h5008, 64'h07C0_FFFF}
   };

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Called just after a rising edge; returns 1 ns after the next one.
   task automatic entry(input logic [4:0] c, input logic [63:0] pc,
                        input logic [63:0] msr, input logic [63:0] pfx);
      exc_valid = 1'b1; exc_cause = c; cur_pc = pc; cur_msr = msr; exc_prefix = pfx;
      @(posedge clk); #1;
      exc_valid = 1'b0; ret_valid = 1'b0;
   endtask

   task automatic do_return(input logic [1:0] k, input logic keep, input logic [63:0] msr);
      ret_valid = 1'b1; ret_kind = k; ret_keep_hi = keep; cur_msr = msr;
      @(posedge clk); #1;
      ret_valid = 1'b0;
   endtask

   initial begin
      repeat (10000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 new_pc", c_pc, 64'h0);
      chk("R1 new_msr", c_msr, 64'h0);
      chk("R1 pulses", {60'h0, c_tk, c_rd, c_ve, c_cs}, 64'h0);
      chk("R1 save_pc", c_spc[0] | c_spc[1] | c_spc[2], 64'h0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      foreach (TBL[i]) begin
         entry(TBL[i].cause, TBL[i].pc, TBL[i].msr, TBL[i].pfx);
         chk("R6 taken", 64'(c_tk), 64'h1);
         chk("R6 handler address", c_pc, TBL[i].x_npc);
         chk("R4 R5 handler state", c_msr, TBL[i].x_nmsr);
         chk("R3 R8 saved address", c_spc[TBL[i].pair], TBL[i].x_spc);
         chk("R2 saved state", c_smsr[TBL[i].pair], TBL[i].x_smsr);
      end

      // R7 undefined vector: pair 0 keeps 0x5008
      entry(5'd30, 64'hAAA0, 64'h1000, 64'h0);
      chk("R7 vec_err", 64'(c_ve), 64'h1);
      chk("R7 no taken", 64'(c_tk), 64'h0);
      chk("R7 pair0 untouched", c_spc[0], 64'h5008);

      // R9 R10 classic returns from pair 0
      entry(5'd5, 64'h6003, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      chk("R2 saved all-ones", c_smsr[0], 64'hFFFF_FFFF_87C0_FFFF);
      do_return(2'd0, 1'b1, 64'h1234_5678_0000_0000);
      chk("R9 ret_done", 64'(c_rd), 64'h1);
      chk("R9 aligned pc", c_pc, 64'h6000);
      chk("R10 keep high", c_msr, 64'h1234_5678_87C0_FFFF);
      do_return(2'd0, 1'b0, 64'h1234_5678_0000_0000);
      chk("R10 no keep", c_msr, 64'hFFFF_FFFF_87C0_FFFF);

      // R9 legacy critical return from pair 1
      entry(5'd1, 64'h7000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      do_return(2'd1, 1'b0, 64'h0);
      chk("R9 legacy pc", c_pc, 64'h7000);
      chk("R9 legacy mask", c_msr, 64'hFFFF_FFFF_0000_FFFF);

      // R2 R8 embedded variant and alternate pair
      entry(5'd2, 64'h8000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
      chk("R2 embedded unmasked", e_smsr[0], 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R8 alt pair pc", e_spc[2], 64'h8000);
      chk("R8 alt pair state", e_smsr[2], 64'hFFFF_FFFF_FFFF_FFFF);
      do_return(2'd3, 1'b0, 64'h0);
      chk("R9 alt return pc", e_pc, 64'h8000);
      chk("R9 alt return state", e_msr, 64'hFFFF_FFFF_FFFF_FFFF);

      // R11 return alongside an entry
      ret_valid = 1'b1; ret_kind = 2'd2; ret_keep_hi = 1'b0;
      entry(5'd5, 64'h9000, 64'h1000, 64'h0);
      chk("R11 entry first", 64'(c_tk), 64'h1);
      chk("R11 return held", 64'(c_rd), 64'h0);
      @(posedge clk); #1;
      chk("R11 held ret_done", 64'(c_rd), 64'h1);
      chk("R11 restored pc", c_pc, 64'h9000);
      chk("R11 restored state", c_msr, 64'h1000);

      // R5 checkstop
      entry(5'd2, 64'hA000, 64'h0, 64'h0);
      chk("R5 checkstop", 64'(c_cs), 64'h1);
      chk("R5 no vector", 64'(c_tk), 64'h0);
      chk("R5 pair0 untouched", c_spc[0], 64'h9000);
      entry(5'd5, 64'hB000, 64'h1000, 64'h0);
      chk("R5 entry ignored", 64'(c_tk), 64'h0);
      chk("R5 pc held", c_pc, 64'h9000);
      do_return(2'd2, 1'b0, 64'h0);
      chk("R5 return ignored", 64'(c_rd), 64'h0);
      chk("R5 still stopped", 64'(c_cs), 64'h1);

      report();
   end
endmodule